// File: doc/BRIEF.md
# Instrument Bus Address Recognizer

This block watches the command bytes on an 8-bit instrument-bus data path while the attention line is high. It decides whether the device is currently addressed as a talker and/or as a listener. A processor programs two 5-bit address registers and a mode register. The block then tracks the addressed, primary-pending and pass-through states with no further help, except where a secondary address must be approved by software.

Three addressing schemes are available. Primary-only addressing uses a major and a minor address. Extended addressing sequences a primary byte and then a secondary byte entirely on chip. Verified-secondary addressing parks any secondary byte that follows a matched primary in a pass-through register and raises an interrupt. The processor then answers with an accept or reject code. Talk-only and listen-only bits force the addressed outputs without any bus traffic. A status byte reports the whole state.

Top module: `addr_recognizer`

## Requirements
- R1: After a synchronous reset, both addressed outputs, the status byte, the pass-through interrupt and the pass-through byte are all zero. Both address registers reset to address 0 with their talk-disable and listen-disable bits set.
- R2: The 2-bit mode field selects the scheme: 00 none, 01 primary-only, 10 extended, 11 verified-secondary. The talk-only bit forces `talk_addressed` high and the listen-only bit forces `listen_addressed` high, in any mode. In mode 00, listen and talk bytes address nothing.
- R3: The status byte is laid out as follows: bit 7 talk-only, bit 6 listen-only, bit 5 registered `eoi_in`, bit 4 listener-primary pending, bit 3 talker-primary pending, bit 2 listener addressed, bit 1 talker addressed, bit 0 minor (1 when the last matched primary came from register 1).
- R4: In mode 01, a byte whose low 7 bits equal 0x20 plus the register-0 address addresses the listener with minor=0. If the byte instead matches 0x20 plus the register-1 address, the listener is addressed with minor=1. Register 0 wins when both match.
- R5: In mode 01, a byte whose low 7 bits equal 0x40 plus an address addresses the talker in the same way. A register whose listen-disable bit (or talk-disable bit) is set does not match listen bytes (or talk bytes).
- R6: The byte 0x3F clears the listener-addressed state. The byte 0x5F clears the talker-addressed state. A matched listen byte of this device clears the talker-addressed state.
- R7: In mode 10, a listen or talk byte matching register 0 sets the listener-primary or talker-primary pending state. A following byte equal to 0x60 plus the register-1 address converts that state into listener- or talker-addressed. A different secondary byte drops the pending state without addressing.
- R8: Any byte below 0x60 (low 7 bits) drops a pending primary state.
- R9: In mode 11, a primary byte matching register 0 or register 1 sets a pending state. The next secondary byte is latched into `cpt_data` and raises `cpt_irq`. While `cpt_irq` is high, command bytes are ignored.
- R10: While `cpt_irq` is high, the auxiliary code 0x0F accepts (the pending state becomes addressed) and 0x07 rejects (the pending state is dropped). Either code lowers `cpt_irq`; all other codes are ignored.
- R11: A byte is taken only when `cmd_valid` and `atn` are both high. Bit 7 of the byte is ignored.
- R12: A mode-register write clears the addressed, pending, minor and pass-through states.
- R13: An address write updates register 0 when `addr_sel`=0 and register 1 when `addr_sel`=1, with the given address and disable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| atn | input | 1 | Bus attention line; bytes are commands while high |
| cmd_valid | input | 1 | One-cycle strobe, a bus byte is present |
| cmd_data | input | 8 | Bus byte |
| eoi_in | input | 1 | End-or-identify line, mirrored into status |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_sel | input | 2 | Addressing mode field |
| mode_ton | input | 1 | Talk-only bit |
| mode_lon | input | 1 | Listen-only bit |
| addr_wr | input | 1 | Write strobe for an address register |
| addr_sel | input | 1 | Selects register 0 or 1 |
| addr_dt | input | 1 | Talk-disable bit |
| addr_dl | input | 1 | Listen-disable bit |
| addr_val | input | 5 | Address value |
| aux_wr | input | 1 | Strobe for a processor response code |
| aux_code | input | 8 | Response code (0x0F accept, 0x07 reject) |
| talk_addressed | output | 1 | Device is talker (addressed or talk-only) |
| listen_addressed | output | 1 | Device is listener (addressed or listen-only) |
| status | output | 8 | Address status byte |
| cpt_data | output | 8 | Latched pass-through secondary byte |
| cpt_irq | output | 1 | Pass-through awaiting processor response |

## Verification
The bench uses the block's fixed 5-bit address and 8-bit byte widths. It programs distinct major and minor addresses (5 and 9), so a single byte stream can reach every matching branch: the major/minor priority, disable bits, secondary mismatch, and the accept, reject and ignored-code paths. It steps through all four modes in sequence, so the mode-write clearing is exercised between them. A behavioural reference model is compared against the outputs on every clock, in addition to hand-computed values at each step.

// File: rtl/addr_rec_pkg.sv
package addr_rec_pkg;

    localparam int ADDR_W = 5;
    localparam int BYTE_W = 8;
    localparam int CMD_W  = 7;
    localparam logic [CMD_W-1:0] CMD_UNLISTEN = 7'h3F;
    localparam logic [CMD_W-1:0] CMD_UNTALK   = 7'h5F;
    localparam logic [1:0] GRP_LISTEN = 2'b01;
    localparam logic [1:0] GRP_TALK   = 2'b10;
    localparam logic [1:0] GRP_SEC    = 2'b11;
    localparam logic [BYTE_W-1:0] AUX_ACCEPT = 8'h0F;
    localparam logic [BYTE_W-1:0] AUX_REJECT = 8'h07;

    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_PRI  = 2'd1,
        MODE_EXT  = 2'd2,
        MODE_VER  = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        K_OTHER, K_UNL, K_UNT, K_LSN, K_TLK, K_SEC
    } kind_e;

    typedef struct packed {
        logic              dis_talk;
        logic              dis_lsn;
        logic [ADDR_W-1:0] addr;
    } areg_t;

    typedef struct packed {
        amode_e mode;
        logic   ton;
        logic   lon;
    } mreg_t;

    typedef struct packed {
        kind_e kind;
        logic  hit0;
        logic  hit1;
        logic  sec_hit;
    } dec_t;

    typedef struct packed {
        logic la;
        logic ta;
        logic lpas;
        logic tpas;
        logic minor;
        logic cpt_pend;
    } ast_t;

    function automatic kind_e classify(input logic [CMD_W-1:0] c);
        if (c == CMD_UNLISTEN)                   return K_UNL;
        if (c == CMD_UNTALK)                     return K_UNT;
        if (c[CMD_W-1 -: 2] == GRP_LISTEN)       return K_LSN;
        if (c[CMD_W-1 -: 2] == GRP_TALK)         return K_TLK;
        if (c[CMD_W-1 -: 2] == GRP_SEC)          return K_SEC;
        return K_OTHER;
    endfunction

    function automatic logic prim_hit(input kind_e k, input areg_t r,
                                      input logic [ADDR_W-1:0] a);
        if (a != r.addr)  return 1'b0;
        if (k == K_LSN)   return !r.dis_lsn;
        if (k == K_TLK)   return !r.dis_talk;
        return 1'b0;
    endfunction

endpackage

// File: rtl/ar_cfg_regs.sv
module ar_cfg_regs
    import addr_rec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [1:0]        mode_sel,
    input  logic              mode_ton,
    input  logic              mode_lon,
    input  logic              addr_wr,
    input  logic              addr_sel,
    input  logic              addr_dt,
    input  logic              addr_dl,
    input  logic [ADDR_W-1:0] addr_val,
    output mreg_t             mreg,
    output areg_t             areg [2]
);

    localparam areg_t AREG_RST = '{dis_talk: 1'b1, dis_lsn: 1'b1, addr: '0};

    always_ff @(posedge clk) begin
        if (rst) begin
            mreg <= '{mode: MODE_NONE, ton: 1'b0, lon: 1'b0};
        end else if (mode_wr) begin
            mreg <= '{mode: amode_e'(mode_sel), ton: mode_ton, lon: mode_lon};
        end
    end

    for (genvar gi = 0; gi < 2; gi++) begin : g_areg
        always_ff @(posedge clk) begin
            if (rst) begin
                areg[gi] <= AREG_RST;
            end else if (addr_wr && (addr_sel == 1'(gi))) begin
                areg[gi] <= '{dis_talk: addr_dt, dis_lsn: addr_dl, addr: addr_val};
            end
        end
    end

endmodule

// File: rtl/ar_cmd_decode.sv
module ar_cmd_decode
    import addr_rec_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd_data,
    input  areg_t             areg [2],
    output dec_t              dec
);

    logic [CMD_W-1:0]  c7;
    logic [ADDR_W-1:0] low;
    kind_e             k;

    always_comb begin
        c7          = cmd_data[CMD_W-1:0];
        low         = c7[ADDR_W-1:0];
        k           = classify(c7);
        dec.kind    = k;
        dec.hit0    = prim_hit(k, areg[0], low);
        dec.hit1    = prim_hit(k, areg[1], low);
        dec.sec_hit = (k == K_SEC) && (low == areg[1].addr);
    end

endmodule

// File: rtl/ar_state.sv
module ar_state
    import addr_rec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [BYTE_W-1:0] cmd_data,
    input  dec_t              dec,
    input  amode_e            mode,
    input  logic              mode_wr,
    input  logic              aux_wr,
    input  logic [BYTE_W-1:0] aux_code,
    output ast_t              st,
    output logic [BYTE_W-1:0] cpt_q
);

    logic prim_any;
    logic pend_any;

    always_comb begin
        prim_any = dec.hit0 || dec.hit1;
        pend_any = st.lpas || st.tpas;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '0;
            cpt_q <= '0;
        end else if (mode_wr) begin
            st <= '0;
        end else if (st.cpt_pend) begin
            if (aux_wr && aux_code == AUX_ACCEPT) begin
                st.la       <= st.la || st.lpas;
                st.ta       <= st.ta || st.tpas;
                st.lpas     <= 1'b0;
                st.tpas     <= 1'b0;
                st.cpt_pend <= 1'b0;
            end else if (aux_wr && aux_code == AUX_REJECT) begin
                st.lpas     <= 1'b0;
                st.tpas     <= 1'b0;
                st.cpt_pend <= 1'b0;
            end
        end else if (take) begin
            unique case (dec.kind)
                K_UNL: begin
                    st.la   <= 1'b0;
                    st.lpas <= 1'b0;
                    st.tpas <= 1'b0;
                end
                K_UNT: begin
                    st.ta   <= 1'b0;
                    st.lpas <= 1'b0;
                    st.tpas <= 1'b0;
                end
                K_LSN: begin
                    st.lpas <= 1'b0;
                    st.tpas <= 1'b0;
                    if (mode == MODE_PRI && prim_any) begin
                        st.la    <= 1'b1;
                        st.ta    <= 1'b0;
                        st.minor <= !dec.hit0;
                    end else if ((mode == MODE_EXT && dec.hit0) ||
                                 (mode == MODE_VER && prim_any)) begin
                        st.lpas  <= 1'b1;
                        st.ta    <= 1'b0;
                        st.minor <= (mode == MODE_VER) && !dec.hit0;
                    end
                end
                K_TLK: begin
                    st.lpas <= 1'b0;
                    st.tpas <= 1'b0;
                    if (mode == MODE_PRI && prim_any) begin
                        st.ta    <= 1'b1;
                        st.minor <= !dec.hit0;
                    end else if ((mode == MODE_EXT && dec.hit0) ||
                                 (mode == MODE_VER && prim_any)) begin
                        st.tpas  <= 1'b1;
                        st.minor <= (mode == MODE_VER) && !dec.hit0;
                    end
                end
                K_SEC: begin
                    if (mode == MODE_EXT && pend_any) begin
                        if (dec.sec_hit) begin
                            st.la <= st.la || st.lpas;
                            st.ta <= st.ta || st.tpas;
                        end
                        st.lpas <= 1'b0;
                        st.tpas <= 1'b0;
                    end else if (mode == MODE_VER && pend_any) begin
                        cpt_q       <= cmd_data;
                        st.cpt_pend <= 1'b1;
                    end
                end
                default: begin
                    st.lpas <= 1'b0;
                    st.tpas <= 1'b0;
                end
            endcase
        end
    end

    // R7: a single primary pending state at a time
    a_r7_one_pending: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st.lpas, st.tpas}));

    // R9: the pass-through wait exists only in verified-secondary mode
    a_r9_irq_mode3: assert property (@(posedge clk) disable iff (rst)
        st.cpt_pend |-> (mode == MODE_VER));

    // R6: unlisten taken outside a pass-through wait drops the listener
    a_r6_unl_clears: assert property (@(posedge clk) disable iff (rst)
        (take && dec.kind == K_UNL && !st.cpt_pend && !mode_wr) |=> !st.la);

    // R12: mode write clears every address state
    a_r12_mode_clear: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (st == '0));

    // R10: state frozen while waiting without a response
    a_r10_hold_wait: assert property (@(posedge clk) disable iff (rst)
        (st.cpt_pend && !aux_wr && !mode_wr) |=> $stable(st));

endmodule

// File: rtl/addr_recognizer.sv
module addr_recognizer
    import addr_rec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              atn,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_data,
    input  logic              eoi_in,
    input  logic              mode_wr,
    input  logic [1:0]        mode_sel,
    input  logic              mode_ton,
    input  logic              mode_lon,
    input  logic              addr_wr,
    input  logic              addr_sel,
    input  logic              addr_dt,
    input  logic              addr_dl,
    input  logic [4:0]        addr_val,
    input  logic              aux_wr,
    input  logic [7:0]        aux_code,
    output logic              talk_addressed,
    output logic              listen_addressed,
    output logic [7:0]        status,
    output logic [7:0]        cpt_data,
    output logic              cpt_irq
);

    mreg_t mreg;
    areg_t areg [2];
    dec_t  dec;
    ast_t  st;
    logic  eoi_q;
    logic  take;

    assign take = atn && cmd_valid;

    ar_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .mode_wr  (mode_wr),
        .mode_sel (mode_sel),
        .mode_ton (mode_ton),
        .mode_lon (mode_lon),
        .addr_wr  (addr_wr),
        .addr_sel (addr_sel),
        .addr_dt  (addr_dt),
        .addr_dl  (addr_dl),
        .addr_val (addr_val),
        .mreg     (mreg),
        .areg     (areg)
    );

    ar_cmd_decode u_dec (
        .cmd_data (cmd_data),
        .areg     (areg),
        .dec      (dec)
    );

    ar_state u_st (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .cmd_data (cmd_data),
        .dec      (dec),
        .mode     (mreg.mode),
        .mode_wr  (mode_wr),
        .aux_wr   (aux_wr),
        .aux_code (aux_code),
        .st       (st),
        .cpt_q    (cpt_data)
    );

    always_ff @(posedge clk) begin
        if (rst) eoi_q <= 1'b0;
        else     eoi_q <= eoi_in;
    end

    always_comb begin
        talk_addressed   = st.ta || mreg.ton;
        listen_addressed = st.la || mreg.lon;
        cpt_irq          = st.cpt_pend;
        status = {mreg.ton, mreg.lon, eoi_q, st.lpas, st.tpas, st.la, st.ta, st.minor};
    end

    // R2: talk-only always presents the device as talker
    a_r2_ton_talk: assert property (@(posedge clk) disable iff (rst)
        mreg.ton |-> talk_addressed);

endmodule

// File: tb/addr_recognizer_tb.sv
module addr_recognizer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic atn = 1'b0, cmd_valid = 1'b0, eoi_in = 1'b0;
    logic [7:0] cmd_data = '0;
    logic mode_wr = 1'b0, mode_ton = 1'b0, mode_lon = 1'b0;
    logic [1:0] mode_sel = '0;
    logic addr_wr = 1'b0, addr_sel = 1'b0, addr_dt = 1'b0, addr_dl = 1'b0;
    logic [4:0] addr_val = '0;
    logic aux_wr = 1'b0;
    logic [7:0] aux_code = '0;
    logic talk_addressed, listen_addressed, cpt_irq;
    logic [7:0] status, cpt_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_recognizer dut_i (
        .clk(clk), .rst(rst), .atn(atn), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .eoi_in(eoi_in), .mode_wr(mode_wr), .mode_sel(mode_sel), .mode_ton(mode_ton),
        .mode_lon(mode_lon), .addr_wr(addr_wr), .addr_sel(addr_sel), .addr_dt(addr_dt),
        .addr_dl(addr_dl), .addr_val(addr_val), .aux_wr(aux_wr), .aux_code(aux_code),
        .talk_addressed(talk_addressed), .listen_addressed(listen_addressed),
        .status(status), .cpt_data(cpt_data), .cpt_irq(cpt_irq)
    );

    // behavioural reference model
    int m_a[2], m_dt[2], m_dl[2];
    int m_mode, m_cpt;
    bit m_ton, m_lon, m_eoi, m_la, m_ta, m_lp, m_tp, m_mi, m_cp;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2; i++) begin m_a[i] = 0; m_dt[i] = 1; m_dl[i] = 1; end
            m_mode = 0; m_cpt = 0;
            {m_ton, m_lon, m_eoi, m_la, m_ta, m_lp, m_tp, m_mi, m_cp} = '0;
        end else begin
            int c, grp, low;
            bit h0, h1;
            m_eoi = eoi_in;
            if (addr_wr) begin
                m_a[addr_sel] = addr_val; m_dt[addr_sel] = addr_dt; m_dl[addr_sel] = addr_dl;
            end
            if (mode_wr) begin
                m_mode = mode_sel; m_ton = mode_ton; m_lon = mode_lon;
                {m_la, m_ta, m_lp, m_tp, m_mi, m_cp} = '0;
            end else if (m_cp) begin
                if (aux_wr && aux_code == 8'h0F) begin
                    if (m_lp) m_la = 1; if (m_tp) m_ta = 1;
                    m_lp = 0; m_tp = 0; m_cp = 0;
                end else if (aux_wr && aux_code == 8'h07) begin
                    m_lp = 0; m_tp = 0; m_cp = 0;
                end
            end else if (atn && cmd_valid) begin
                c = cmd_data % 128; grp = c / 32; low = c % 32;
                if (c == 63)      begin m_la = 0; m_lp = 0; m_tp = 0; end
                else if (c == 95) begin m_ta = 0; m_lp = 0; m_tp = 0; end
                else if (grp == 1 || grp == 2) begin
                    h0 = (low == m_a[0]) && ((grp == 1) ? !m_dl[0] : !m_dt[0]);
                    h1 = (low == m_a[1]) && ((grp == 1) ? !m_dl[1] : !m_dt[1]);
                    m_lp = 0; m_tp = 0;
                    if (m_mode == 1 && (h0 || h1)) begin
                        if (grp == 1) begin m_la = 1; m_ta = 0; end else m_ta = 1;
                        m_mi = !h0;
                    end else if ((m_mode == 2 && h0) || (m_mode == 3 && (h0 || h1))) begin
                        if (grp == 1) begin m_lp = 1; m_ta = 0; end else m_tp = 1;
                        m_mi = (m_mode == 3) && !h0;
                    end
                end else if (grp == 3) begin
                    if (m_mode == 2 && (m_lp || m_tp)) begin
                        if (low == m_a[1]) begin if (m_lp) m_la = 1; if (m_tp) m_ta = 1; end
                        m_lp = 0; m_tp = 0;
                    end else if (m_mode == 3 && (m_lp || m_tp)) begin
                        m_cpt = cmd_data; m_cp = 1;
                    end
                end else begin
                    m_lp = 0; m_tp = 0;
                end
            end
        end
    end

    // cycle compare against the model (R3 layout)
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [7:0] es;
            es = {m_ton, m_lon, m_eoi, m_lp, m_tp, m_la, m_ta, m_mi};
            n_tests++;
            if (status !== es || talk_addressed !== (m_ta | m_ton) ||
                listen_addressed !== (m_la | m_lon) || cpt_irq !== m_cp ||
                cpt_data !== 8'(m_cpt)) begin
                n_fail++;
                $display("FAIL R3 model: status=%h talk=%b lsn=%b irq=%b cpt=%h exp %h %b %b %b %h",
                         status, talk_addressed, listen_addressed, cpt_irq, cpt_data,
                         es, m_ta | m_ton, m_la | m_lon, m_cp, 8'(m_cpt));
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic a = 1'b1);
        @(negedge clk); atn = a; cmd_valid = 1'b1; cmd_data = b;
        @(negedge clk); cmd_valid = 1'b0; atn = 1'b0;
    endtask

    task automatic wr_addr(input logic s, input logic dt, input logic dl, input logic [4:0] v);
        @(negedge clk); addr_wr = 1'b1; addr_sel = s; addr_dt = dt; addr_dl = dl; addr_val = v;
        @(negedge clk); addr_wr = 1'b0;
    endtask

    task automatic wr_mode(input logic [1:0] m, input logic t, input logic l);
        @(negedge clk); mode_wr = 1'b1; mode_sel = m; mode_ton = t; mode_lon = l;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic aux(input logic [7:0] code);
        @(negedge clk); aux_wr = 1'b1; aux_code = code;
        @(negedge clk); aux_wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 status", status, 8'h00);
        check("R1 outputs", {talk_addressed, listen_addressed, cpt_irq}, 8'h00);
        check("R1 cpt", cpt_data, 8'h00);
        send(8'h25);
        check("R1 disabled regs", status, 8'h00);   // mode 00 and disabled registers

        wr_addr(1'b0, 1'b0, 1'b0, 5'd5);
        wr_addr(1'b1, 1'b0, 1'b0, 5'd9);
        wr_mode(2'd1, 1'b0, 1'b0);
        send(8'h25); check("R4 major listen", status, 8'h04);
        check("R4 listen out", {7'd0, listen_addressed}, 8'h01);
        send(8'h29); check("R4 minor listen", status, 8'h05);
        send(8'h3F); check("R6 unlisten", status, 8'h01);
        send(8'h45); check("R5 major talk", status, 8'h02);
        send(8'h25); check("R6 MLA clears talker", status, 8'h04);
        send(8'hC9); check("R11 bit7 ignored, R5 minor talk", status, 8'h07);
        send(8'h3F, 1'b0); check("R11 atn low ignored", status, 8'h07);
        send(8'h5F); check("R6 untalk", status, 8'h05);
        check("R6 talk out", {7'd0, talk_addressed}, 8'h00);
        wr_addr(1'b1, 1'b0, 1'b1, 5'd9);
        send(8'h3F); send(8'h29); check("R13 R5 listen disable", status, 8'h01);
        wr_addr(1'b0, 1'b1, 1'b0, 5'd5);
        send(8'h45); check("R5 talk disable", {7'd0, talk_addressed}, 8'h00);
        wr_addr(1'b0, 1'b0, 1'b0, 5'd5);

        wr_mode(2'd2, 1'b0, 1'b0); check("R12 mode write clears", status, 8'h00);
        send(8'h25); check("R7 listen pending", status, 8'h10);
        send(8'h69); check("R7 secondary addresses", status, 8'h04);
        send(8'h45); check("R7 talk pending", status, 8'h0C);
        send(8'h12); check("R8 cancel pending", status, 8'h04);
        send(8'h45); send(8'h6A); check("R7 mismatched secondary", status, 8'h04);
        send(8'h45); send(8'h69); check("R7 talker addressed", status, 8'h06);

        wr_mode(2'd3, 1'b0, 1'b0);
        send(8'h25); check("R9 pending", status, 8'h10);
        send(8'h71); check("R9 cpt irq", {7'd0, cpt_irq}, 8'h01);
        check("R9 cpt byte", cpt_data, 8'h71);
        send(8'h3F); check("R9 bytes ignored in wait", status, 8'h10);
        aux(8'h55); check("R10 other code ignored", {7'd0, cpt_irq}, 8'h01);
        aux(8'h0F); check("R10 accept", status, 8'h04);
        check("R10 irq low", {7'd0, cpt_irq}, 8'h00);
        send(8'hC5); send(8'h62); check("R9 second capture", cpt_data, 8'h62);
        aux(8'h07); check("R10 reject", status, 8'h04);
        send(8'h49); check("R9 minor primary", status, 8'h0D);
        send(8'h60); aux(8'h0F); check("R10 accept talker", status, 8'h07);

        wr_mode(2'd0, 1'b1, 1'b0); check("R2 talk-only", status, 8'h80);
        check("R2 talk out", {6'd0, talk_addressed, listen_addressed}, 8'h02);
        send(8'h25); check("R2 mode 00 ignores", status, 8'h80);
        wr_mode(2'd0, 1'b0, 1'b1);
        check("R2 listen-only", {6'd0, talk_addressed, listen_addressed}, 8'h01);
        @(negedge clk); eoi_in = 1'b1;
        @(negedge clk); check("R3 eoi bit", status, 8'h60);
        eoi_in = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule